// File: doc/BRIEF.md
# Programmable-Latency Interrupt Priority Resolver

This block arbitrates among sixteen maskable interrupt sources for a CPU core. Each source has a pending request bit, which a one-cycle hardware pulse sets, and a 3-bit priority level that software can rewrite at any time through a small configuration port. When the CPU signals an opcode fetch and the resolver is idle, the block takes a snapshot of every request bit and every level. It then runs a countdown whose length software chooses from three values, and when the countdown ends it reports the winning source.

The winner is held until the next instruction boundary. At that boundary it is accepted only if its level is strictly above the current processor interrupt priority level (IPL) and the interrupt-disable flag is clear. On acceptance the block pulses an accept output with the vector index, clears that source's request bit, and raises the IPL to the winner's level. Otherwise the held result is dropped and nothing changes. A separate force input lets the core load the IPL directly, for example to 7 on a watchdog or debug event. Software traps do not use the force input, so they leave the IPL untouched.

Top module: `irq_prio_resolver`

## Requirements
- R1: Source positions are fixed: 0 A/D conversion, 1 serial-0 transmit, 2 serial-0 receive, 3 serial-1 transmit, 4 serial-1 receive, 5..9 A-type timers 0..4, 10..12 B-type timers 0..2, 13..15 external pins 0..2. A one-cycle pulse on `req_set[i]` makes `req_pending[i]` read 1 from the next cycle until the source is accepted.
- R2: A write with `cfg_we` high stores `cfg_lvl` as the level of source `cfg_idx`. The write may happen at any time and is used from the next snapshot on.
- R3: A cycle with `fetch_strobe` high, while the block is neither resolving nor holding a result, snapshots all request bits and levels. `busy` reads 1 from the next cycle.
- R4: `res_done` pulses exactly N cycles after the snapshot edge. N is 7 for `sel_val` 00, 4 for 01, and 2 for 10 or 11. The code is written with `sel_we` and read at the snapshot edge.
- R5: After reset the latency code is 00, so a resolution takes 7 cycles.
- R6: While resolving or holding a result, `fetch_strobe` is ignored. Requests or level writes made during that time do not affect the pending result, and they take part in the next snapshot.
- R7: The winner is the snapshotted request with the highest level. Level 0 means disabled and never wins. When levels tie, the lowest source position wins. `res_found` is 0 when no source qualifies.
- R8: At an `insn_boundary` cycle while a found result is held, the result is accepted if its level is greater than `ipl` and `i_flag` is low. On acceptance, in the next cycle `irq_accept` is 1, `irq_vec` equals the winner, `ipl` equals the winner's level, and its `req_pending` bit is 0. Otherwise the result is discarded, and `ipl` and the request bits keep their values.
- R9: Reset sets `ipl` to 0. A cycle with `ipl_force_we` high loads `ipl_force_val` into `ipl` for the next cycle, and it takes precedence over an acceptance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 16 | One-cycle request pulses, one per source |
| cfg_we | input | 1 | Level write enable |
| cfg_idx | input | 4 | Source whose level is written |
| cfg_lvl | input | 3 | New priority level |
| sel_we | input | 1 | Latency code write enable |
| sel_val | input | 2 | Latency code |
| fetch_strobe | input | 1 | Opcode-fetch cycle indication from the CPU |
| insn_boundary | input | 1 | Instruction boundary, where acceptance is decided |
| i_flag | input | 1 | Interrupt-disable flag |
| ipl_force_we | input | 1 | Load the IPL directly |
| ipl_force_val | input | 3 | Value for the direct IPL load |
| req_pending | output | 16 | Current request bits |
| busy | output | 1 | Resolution countdown running |
| res_done | output | 1 | One-cycle pulse when a resolution completes |
| res_found | output | 1 | Last resolution found a qualifying source |
| res_idx | output | 4 | Winner of the last resolution |
| irq_accept | output | 1 | One-cycle acceptance pulse |
| irq_vec | output | 4 | Index of the accepted source |
| ipl | output | 3 | Processor interrupt priority level |

## Verification
A request pulse shows on `req_pending` one cycle after it is driven, and `busy` rises one cycle after the snapshot edge. `res_done`, `res_found` and `res_idx` arrive N cycles after the snapshot edge, and `irq_accept`, `irq_vec` and the new `ipl` arrive one cycle after the boundary edge. The bench drives and samples on falling edges. It counts the falling edges between the snapshot and the first one that shows `res_done`, and it compares that count with 7, 4 or 2. It reads the accept outputs on the falling edge right after the boundary cycle. A request and a second fetch strobe are injected in the middle of a countdown, and the bench checks that the winner still comes from the earlier snapshot and that the late request wins at the next snapshot.

// File: rtl/irq_prio_pkg.sv
// Package: shared sizes and the fixed source ordering of the interrupt
// priority resolver. Assumes at most 16 sources unless IDX_W is widened.
package irq_prio_pkg;

    localparam int NUM_SRC = 16;
    localparam int LVL_W   = 3;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int SEL_W   = 2;

    // Fixed source positions; lower position wins a level tie.
    typedef enum logic [IDX_W-1:0] {
        SRC_ADC     = 4'd0,
        SRC_SER0_TX = 4'd1,
        SRC_SER0_RX = 4'd2,
        SRC_SER1_TX = 4'd3,
        SRC_SER1_RX = 4'd4,
        SRC_TA0     = 4'd5,
        SRC_TA1     = 4'd6,
        SRC_TA2     = 4'd7,
        SRC_TA3     = 4'd8,
        SRC_TA4     = 4'd9,
        SRC_TB0     = 4'd10,
        SRC_TB1     = 4'd11,
        SRC_TB2     = 4'd12,
        SRC_EXT0    = 4'd13,
        SRC_EXT1    = 4'd14,
        SRC_EXT2    = 4'd15
    } src_id_e;

endpackage

// File: rtl/irq_src_bank.sv
// Module: per-source request bits, priority levels and the frozen snapshot
// used during a resolution. Assumes snap_en is only raised when the
// resolver is idle; a set pulse wins over a clear in the same cycle so no
// new event is lost.
module irq_src_bank #(
    parameter int N  = irq_prio_pkg::NUM_SRC,
    parameter int LW = irq_prio_pkg::LVL_W,
    parameter int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_set,
    input  logic [N-1:0]         clr_mask,
    input  logic                 cfg_we,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [LW-1:0]        cfg_lvl,
    input  logic                 snap_en,
    output logic [N-1:0]         req_q,
    output logic [N-1:0]         snap_req,
    output logic [N-1:0][LW-1:0] snap_lvl
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_src
            logic          r_q;
            logic [LW-1:0] l_q;
            logic          sr_q;
            logic [LW-1:0] sl_q;

            // Request bit: set pulse has priority over acceptance clear.
            always_ff @(posedge clk) begin
                if (!rst_n)            r_q <= 1'b0;
                else if (req_set[g])   r_q <= 1'b1;
                else if (clr_mask[g])  r_q <= 1'b0;
            end

            // Priority level: software rewrite through the config port.
            always_ff @(posedge clk) begin
                if (!rst_n)                               l_q <= '0;
                else if (cfg_we && (cfg_idx == IW'(g)))   l_q <= cfg_lvl;
            end

            // Snapshot: frozen copy of request and level for arbitration.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sr_q <= 1'b0;
                    sl_q <= '0;
                end else if (snap_en) begin
                    sr_q <= r_q;
                    sl_q <= l_q;
                end
            end

            assign req_q[g]    = r_q;
            assign snap_req[g] = sr_q;
            assign snap_lvl[g] = sl_q;
        end
    endgenerate

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_mask)); // R8

endmodule

// File: rtl/irq_lat_timer.sv
// Module: holds the software latency code and runs the resolution
// countdown. Assumes LAT_A is the longest latency and every latency is at
// least 1. done is high in the last busy cycle; the caller registers it.
module irq_lat_timer #(
    parameter int SW    = irq_prio_pkg::SEL_W,
    parameter int LAT_A = 7,
    parameter int LAT_B = 4,
    parameter int LAT_C = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_we,
    input  logic [SW-1:0] sel_val,
    input  logic          start,
    output logic          busy,
    output logic          done
);

    localparam int CW = (LAT_A > 2) ? $clog2(LAT_A) : 1;

    logic [SW-1:0] sel_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [CW-1:0] load_val;

    // Latency code register; reset selects the longest latency.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= sel_val;
    end

    // Map the code to a countdown preload; unused codes take the shortest.
    always_comb begin
        if (sel_q == SW'(0))      load_val = CW'(LAT_A - 1);
        else if (sel_q == SW'(1)) load_val = CW'(LAT_B - 1);
        else                      load_val = CW'(LAT_C - 1);
    end

    // Countdown: preload on start, end the run when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val;
        end else if (busy_q && (cnt_q == '0)) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= CW'(LAT_A - 1))); // R4

endmodule

// File: rtl/irq_winner.sv
// Module: combinational arbitration over the frozen snapshot. Highest level
// wins, level 0 never wins, ties go to the lowest position. Assumes the
// inputs are stable for the whole resolution window.
module irq_winner #(
    parameter int N  = irq_prio_pkg::NUM_SRC,
    parameter int LW = irq_prio_pkg::LVL_W,
    parameter int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic [N-1:0][LW-1:0] lvl,
    output logic                 found,
    output logic [IW-1:0]        idx,
    output logic [LW-1:0]        win_lvl
);

    // Ascending scan with strict compare keeps the lowest index on a tie.
    always_comb begin
        found   = 1'b0;
        idx     = '0;
        win_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (lvl[i] > win_lvl)) begin
                found   = 1'b1;
                idx     = IW'(i);
                win_lvl = lvl[i];
            end
        end
    end

    AST_WIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (req[idx] && (lvl[idx] != '0))); // R7

endmodule

// File: rtl/irq_prio_resolver.sv
// Module: top of the interrupt priority resolver. Samples on an opcode
// fetch when idle, waits the programmed latency, holds the winner until an
// instruction boundary, then accepts or drops it against IPL and i_flag.
// Assumes insn_boundary and fetch_strobe are single-cycle indications.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int N_SRC    = NUM_SRC,
    parameter int LVL_BITS = LVL_W,
    parameter int IDX_BITS = $clog2(N_SRC),
    parameter int SEL_BITS = SEL_W,
    parameter int LAT_SLOW = 7,
    parameter int LAT_MID  = 4,
    parameter int LAT_FAST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    req_set,
    input  logic                cfg_we,
    input  logic [IDX_BITS-1:0] cfg_idx,
    input  logic [LVL_BITS-1:0] cfg_lvl,
    input  logic                sel_we,
    input  logic [SEL_BITS-1:0] sel_val,
    input  logic                fetch_strobe,
    input  logic                insn_boundary,
    input  logic                i_flag,
    input  logic                ipl_force_we,
    input  logic [LVL_BITS-1:0] ipl_force_val,
    output logic [N_SRC-1:0]    req_pending,
    output logic                busy,
    output logic                res_done,
    output logic                res_found,
    output logic [IDX_BITS-1:0] res_idx,
    output logic                irq_accept,
    output logic [IDX_BITS-1:0] irq_vec,
    output logic [LVL_BITS-1:0] ipl
);

    logic                         snap_en;
    logic                         tmr_busy;
    logic                         tmr_done;
    logic [N_SRC-1:0]             snap_req;
    logic [N_SRC-1:0][LVL_BITS-1:0] snap_lvl;
    logic [N_SRC-1:0]             clr_mask;
    logic                         win_found;
    logic [IDX_BITS-1:0]          win_idx;
    logic [LVL_BITS-1:0]          win_lvl;

    logic                         hold_q;
    logic                         done_q;
    logic                         found_q;
    logic [IDX_BITS-1:0]          idx_q;
    logic [LVL_BITS-1:0]          lvl_q;
    logic                         acc_q;
    logic [IDX_BITS-1:0]          vec_q;
    logic [LVL_BITS-1:0]          ipl_q;
    logic                         accept_now;

    // Sampling pulse only when neither counting nor holding a result.
    assign snap_en = fetch_strobe && !tmr_busy && !hold_q;

    // Acceptance decision at the instruction boundary.
    assign accept_now = hold_q && insn_boundary && !i_flag && (lvl_q > ipl_q);

    // One-hot clear of the accepted source's request bit.
    always_comb begin
        clr_mask = '0;
        if (accept_now) clr_mask[idx_q] = 1'b1;
    end

    irq_src_bank #(
        .N  (N_SRC),
        .LW (LVL_BITS),
        .IW (IDX_BITS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (req_set),
        .clr_mask (clr_mask),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_lvl  (cfg_lvl),
        .snap_en  (snap_en),
        .req_q    (req_pending),
        .snap_req (snap_req),
        .snap_lvl (snap_lvl)
    );

    irq_lat_timer #(
        .SW    (SEL_BITS),
        .LAT_A (LAT_SLOW),
        .LAT_B (LAT_MID),
        .LAT_C (LAT_FAST)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (sel_we),
        .sel_val (sel_val),
        .start   (snap_en),
        .busy    (tmr_busy),
        .done    (tmr_done)
    );

    irq_winner #(
        .N  (N_SRC),
        .LW (LVL_BITS),
        .IW (IDX_BITS)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (snap_req),
        .lvl     (snap_lvl),
        .found   (win_found),
        .idx     (win_idx),
        .win_lvl (win_lvl)
    );

    // Result register: capture winner at end of countdown, hold to boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            hold_q  <= 1'b0;
            found_q <= 1'b0;
            idx_q   <= '0;
            lvl_q   <= '0;
        end else begin
            done_q <= tmr_done;
            if (tmr_done) begin
                hold_q  <= win_found;
                found_q <= win_found;
                idx_q   <= win_idx;
                lvl_q   <= win_lvl;
            end else if (insn_boundary) begin
                hold_q  <= 1'b0;
            end
        end
    end

    // Accept pulse and vector towards the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            vec_q <= '0;
        end else begin
            acc_q <= accept_now;
            if (accept_now) vec_q <= idx_q;
        end
    end

    // IPL: a forced load overrides an acceptance in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)            ipl_q <= '0;
        else if (ipl_force_we) ipl_q <= ipl_force_val;
        else if (accept_now)   ipl_q <= lvl_q;
    end

    assign busy       = tmr_busy;
    assign res_done   = done_q;
    assign res_found  = found_q;
    assign res_idx    = idx_q;
    assign irq_accept = acc_q;
    assign irq_vec    = vec_q;
    assign ipl        = ipl_q;

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> $past(busy)); // R4
    AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> ($past(insn_boundary) && !$past(i_flag))); // R8
    AST_IPL_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && !$past(ipl_force_we)) |-> (ipl > $past(ipl))); // R8
    AST_IPL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ipl_force_we) && $past(rst_n)) |-> (ipl == $past(ipl_force_val))); // R9

endmodule

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_set = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [2:0]  cfg_lvl = '0;
    logic        sel_we = 1'b0;
    logic [1:0]  sel_val = '0;
    logic        fetch_strobe = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        i_flag = 1'b0;
    logic        ipl_force_we = 1'b0;
    logic [2:0]  ipl_force_val = '0;
    logic [15:0] req_pending;
    logic        busy;
    logic        res_done;
    logic        res_found;
    logic [3:0]  res_idx;
    logic        irq_accept;
    logic [3:0]  irq_vec;
    logic [2:0]  ipl;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model state
    logic [15:0] mreq = '0;
    int          mlvl[16];
    int          mipl = 0;
    int          msel = 0;
    int          exp_win = -1;

    always #10 clk = ~clk;

    irq_prio_resolver u_irq_prio_resolver (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .sel_we(sel_we), .sel_val(sel_val),
        .fetch_strobe(fetch_strobe), .insn_boundary(insn_boundary), .i_flag(i_flag),
        .ipl_force_we(ipl_force_we), .ipl_force_val(ipl_force_val),
        .req_pending(req_pending), .busy(busy), .res_done(res_done),
        .res_found(res_found), .res_idx(res_idx), .irq_accept(irq_accept),
        .irq_vec(irq_vec), .ipl(ipl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lat_of(input int s);
        if (s == 0) return 7;
        if (s == 1) return 4;
        return 2;
    endfunction

    // Reference: walk levels from the top down, positions from the bottom up.
    function automatic int ref_winner(input logic [15:0] r);
        for (int lv = 7; lv >= 1; lv--)
            for (int i = 0; i < 16; i++)
                if (r[i] && mlvl[i] == lv) return i;
        return -1;
    endfunction

    task automatic set_lvl(input int idx, input int lv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_lvl = 3'(lv);
        @(negedge clk);
        cfg_we = 1'b0;
        mlvl[idx] = lv;
    endtask

    task automatic set_sel(input int s);
        @(negedge clk);
        sel_we = 1'b1; sel_val = 2'(s);
        @(negedge clk);
        sel_we = 1'b0;
        msel = s;
    endtask

    task automatic raise(input logic [15:0] m);
        @(negedge clk);
        req_set = m;
        @(negedge clk);
        req_set = '0;
        mreq = mreq | m;
    endtask

    task automatic force_ipl(input int v);
        @(negedge clk);
        ipl_force_we = 1'b1; ipl_force_val = 3'(v);
        @(negedge clk);
        ipl_force_we = 1'b0;
        mipl = v;
        chk("R9 forced ipl", int'(ipl), v);
    endtask

    // Snapshot, count falling edges to res_done, optionally inject mid-run.
    task automatic resolve(input string tag, input int inj_at, input logic [15:0] inj);
        int cyc;
        exp_win = ref_winner(mreq);
        @(negedge clk);
        fetch_strobe = 1'b1;
        @(negedge clk);
        fetch_strobe = 1'b0;
        cyc = 0;
        chk({tag, " R3 busy after snapshot"}, int'(busy), 1);
        while (!res_done && cyc < 20) begin
            if (cyc == inj_at) begin
                req_set = inj;
                fetch_strobe = 1'b1;
            end
            @(negedge clk);
            req_set = '0;
            fetch_strobe = 1'b0;
            cyc++;
        end
        if (inj_at >= 0) mreq = mreq | inj;
        chk({tag, " R4 latency"}, cyc, lat_of(msel));
        chk({tag, " R7 found"}, int'(res_found), (exp_win >= 0) ? 1 : 0);
        if (exp_win >= 0) chk({tag, " R7 winner"}, int'(res_idx), exp_win);
    endtask

    task automatic boundary(input string tag, input bit flag);
        bit acc;
        acc = (exp_win >= 0) && (mlvl[exp_win] > mipl) && !flag;
        @(negedge clk);
        insn_boundary = 1'b1; i_flag = flag;
        @(negedge clk);
        insn_boundary = 1'b0; i_flag = 1'b0;
        chk({tag, " R8 accept"}, int'(irq_accept), int'(acc));
        if (acc) begin
            mipl = mlvl[exp_win];
            mreq[exp_win] = 1'b0;
            chk({tag, " R8 vector"}, int'(irq_vec), exp_win);
        end
        chk({tag, " R8 ipl"}, int'(ipl), mipl);
        chk({tag, " R1 pending"}, int'(req_pending), int'(mreq));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mlvl[i] = 0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ipl", int'(ipl), 0);
        chk("R1 reset pending", int'(req_pending), 0);
        chk("R3 reset busy", int'(busy), 0);
        chk("R8 reset accept", int'(irq_accept), 0);

        // R5: default latency code gives 7 cycles
        set_lvl(3, 2);
        raise(16'h0008);
        chk("R1 request visible", int'(req_pending), 16'h0008);
        resolve("R5 default", -1, '0);
        boundary("R8 first", 1'b0);

        // R7 tie at level 4 goes to position 5
        set_sel(1);
        set_lvl(5, 4);
        set_lvl(9, 4);
        raise(16'h0220);
        resolve("R7 tie", -1, '0);
        boundary("R8 tie", 1'b0);

        // level equal to ipl is rejected; code 10 and 11 both give 2
        set_sel(2);
        resolve("R4 fast", -1, '0);
        boundary("R8 equal ipl", 1'b0);
        set_sel(3);
        resolve("R4 code3", -1, '0);
        boundary("R8 code3", 1'b0);

        // R2: rewriting a level to 0 disables that source
        set_lvl(9, 0);
        resolve("R2 disabled", -1, '0);
        boundary("R2 disabled", 1'b0);

        // R8: i_flag blocks acceptance
        set_lvl(12, 6);
        raise(16'h1000);
        resolve("R8 iflag", -1, '0);
        boundary("R8 iflag", 1'b1);

        // R6: late request and fetch strobe mid-countdown are ignored
        set_sel(0);
        set_lvl(0, 7);
        resolve("R6 inject", 2, 16'h0001);
        chk("R6 late request held", int'(req_pending[0]), 1);
        boundary("R6 inject", 1'b0);
        resolve("R6 next sample", -1, '0);
        chk("R6 late request wins next", int'(res_idx), 0);
        boundary("R6 next sample", 1'b0);

        // R9: forced loads
        force_ipl(7);
        force_ipl(0);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            for (int s = 0; s < 16; s++) set_lvl(s, int'($urandom % 8));
            if ($urandom % 3 == 0) force_ipl(int'($urandom % 8));
            set_sel(int'($urandom % 4));
            raise(16'($urandom & $urandom));
            resolve("R7 random", -1, '0);
            boundary("R8 random", ($urandom % 4) == 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule